// File: doc/BRIEF.md
# Programmable Bit-Rate Tick Generator

This block produces the receive bit timing for a serial data path running from a fixed 10 MHz reference clock. A chain of three dividers sets the bit period: a fixed divide-by-29 stage, an optional divide-by-8 stage turned on by a single select bit, and a 7-bit programmable stage that divides by (R+1). The bit rate is 10 MHz / 29 / (R+1) / (1 + 7·cs). With these settings the standard rates from 600 bps to 115.2 kbps can be reached with small error.

Software or a control engine writes a 16-bit command word to set the rate. The upper byte of the word is an operation code, and the block only accepts words that carry its own code. A new setting is held as pending. It becomes active at the next bit boundary, and at that point every divider restarts from zero, so no period is ever cut short.

The block has two outputs, each a one-cycle pulse in the reference domain. The bit tick marks the end of each bit period. The half tick marks the middle of the period, so a downstream sampler can use it to sample at mid-bit.

Top module: `rate_tick_gen`

## Requirements
- R1: After a synchronous reset, both tick outputs are low and the active setting is cs=0, R=35. The first bit tick appears on the 1044th clock edge after reset is released.
- R2: While a setting is active, consecutive bit ticks are exactly 29·(R+1)·(1+7·cs) reference cycles apart.
- R3: Each bit tick is high for exactly one clock cycle.
- R4: The half tick is a one-cycle pulse that comes floor(P/2) cycles after each bit tick, where P is the active period. Its first occurrence after reset follows the same rule. It never coincides with a bit tick.
- R5: A command word is accepted only when bits 15:8 equal C8h. In an accepted word, bit 7 is cs (1 selects the extra divide-by-8) and bits 6:0 are R.
- R6: A command write whose bits 15:8 differ from C8h has no effect on the tick timing.
- R7: An accepted setting does not change the bit period that is in progress. It takes effect at the next bit tick boundary, and the full new period follows that boundary.
- R8: If several accepted writes arrive within one bit period, only the last one applies at the boundary.
- R9: The extreme settings R=0 with cs=0 (period 29) and R=127 with cs=1 (period 29696) both give exact periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe, one cycle per write |
| cmd_word | input | 16 | Command word: operation code, prescale select, divider value |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |
| half_tick | output | 1 | One-cycle pulse at the middle of each bit period |

## Verification
The bench builds the block with its default parameters: a base divide of 29, a slow-mode divide of 8, a 7-bit divider field and operation code C8h. These values keep the whole period range, from 29 to 29696 cycles, short enough to cover in one run. Both extremes are therefore timed end to end, along with the reset default of 1044 and a slow-mode period of 1392. A behavioural model predicts every cycle of both outputs. Its timing is compared against interval measurements taken around ignored writes, boundary changeover and back-to-back writes inside a single period.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  parameter int unsigned RATE_W = 7;

  typedef struct packed {
    logic              slow;
    logic [RATE_W-1:0] div;
  } rate_cfg_t;

  localparam rate_cfg_t RATE_DEFAULT = '{slow: 1'b0, div: RATE_W'(35)};
endpackage

// File: rtl/rtg_cmd_decode.sv
module rtg_cmd_decode
  import rtg_pkg::*;
#(
  parameter int unsigned CMD_W     = 16,
  parameter int unsigned OP_W      = 8,
  parameter logic [7:0]  OPCODE    = 8'hC8,
  parameter rate_cfg_t   RESET_CFG = RATE_DEFAULT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_word,
  input  logic             load,
  output rate_cfg_t        pend_cfg,
  output rate_cfg_t        act_cfg
);
  logic      accept;
  rate_cfg_t decoded;

  always_comb begin
    accept       = cmd_wr && (cmd_word[CMD_W-1 -: OP_W] == OP_W'(OPCODE));
    decoded.slow = cmd_word[RATE_W];
    decoded.div  = cmd_word[RATE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cfg <= RESET_CFG;
      act_cfg  <= RESET_CFG;
    end else begin
      if (accept) pend_cfg <= decoded;
      if (load)   act_cfg  <= pend_cfg;
    end
  end

  // R5: an accepted word lands in the pending setting field by field
  assert_cmd_fields_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> (pend_cfg.slow == $past(cmd_word[RATE_W])) &&
               (pend_cfg.div  == $past(cmd_word[RATE_W-1:0])));

  // R6: foreign operation codes leave the pending setting alone
  assert_foreign_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !accept) |=> $stable(pend_cfg));

  // R7: the active setting only moves at a bit boundary
  assert_load_boundary_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_cfg));
endmodule

// File: rtl/rtg_prescale.sv
module rtg_prescale
  import rtg_pkg::*;
#(
  parameter int unsigned BASE_DIV = 29,
  parameter int unsigned SLOW_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic slow,
  output logic stage_en
);
  localparam int unsigned C1W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [C1W-1:0] C1_LAST = C1W'(BASE_DIV - 1);

  logic [C1W-1:0] c1;
  logic           c1_last;

  assign c1_last = (c1 == C1_LAST);

  always_ff @(posedge clk) begin
    if (rst || restart)  c1 <= '0;
    else if (c1_last)    c1 <= '0;
    else                 c1 <= c1 + 1'b1;
  end

  // R2: base stage never runs past its terminal count
  assert_base_bound_R2: assert property (@(posedge clk) disable iff (rst)
    c1 <= C1_LAST);

  generate
    if (SLOW_DIV > 1) begin : g_slow
      localparam int unsigned C2W = $clog2(SLOW_DIV);
      localparam logic [C2W-1:0] C2_LAST = C2W'(SLOW_DIV - 1);
      logic [C2W-1:0] c2;
      logic           c2_last;

      assign c2_last  = slow ? (c2 == C2_LAST) : 1'b1;
      assign stage_en = c1_last && c2_last;

      always_ff @(posedge clk) begin
        if (rst || restart) c2 <= '0;
        else if (c1_last)   c2 <= c2_last ? '0 : c2 + 1'b1;
      end

      // R2: with the prescaler off its counter stays parked at zero
      assert_fast_bypass_R2: assert property (@(posedge clk) disable iff (rst)
        (!slow && !restart) |=> (c2 == '0));
    end else begin : g_fast
      logic unused_slow;
      assign unused_slow = slow;
      assign stage_en    = c1_last;
    end
  endgenerate
endmodule

// File: rtl/rtg_bit_div.sv
module rtg_bit_div
  import rtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_en,
  input  logic [RATE_W-1:0] div,
  output logic              wrap,
  output logic              bit_tick
);
  logic [RATE_W-1:0] c3;

  assign wrap = stage_en && (c3 == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      c3       <= '0;
      bit_tick <= 1'b0;
    end else begin
      if (wrap)          c3 <= '0;
      else if (stage_en) c3 <= c3 + 1'b1;
      bit_tick <= wrap;
    end
  end

  // R2: the programmable stage never passes the active divider value
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    c3 <= div);

  // R3: a bit tick lasts one cycle
  assert_tick_single_R3: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick);
endmodule

// File: rtl/rtg_half_mark.sv
module rtg_half_mark
  import rtg_pkg::*;
#(
  parameter int unsigned BASE_DIV = 29,
  parameter int unsigned SLOW_DIV = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      restart,
  input  rate_cfg_t act_cfg,
  output logic      half_tick
);
  localparam int unsigned MAX_SPAN = BASE_DIV * (2 ** RATE_W) * SLOW_DIV;
  localparam int unsigned PW       = $clog2(MAX_SPAN + 1) + 1;

  logic [PW-1:0] elapsed;
  logic [PW-1:0] span;
  logic [PW-1:0] half_pt;

  always_comb begin
    span = PW'(BASE_DIV) * (PW'(act_cfg.div) + PW'(1));
    if (act_cfg.slow) span = span * PW'(SLOW_DIV);
    half_pt = span >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed   <= '0;
      half_tick <= 1'b0;
    end else begin
      elapsed   <= restart ? '0 : elapsed + 1'b1;
      half_tick <= (elapsed == half_pt - PW'(1));
    end
  end

  // R2: the phase never exceeds the period of the active setting
  assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
    elapsed < span);

  // R4: the half tick is a single-cycle pulse
  assert_half_single_R4: assert property (@(posedge clk) disable iff (rst)
    half_tick |=> !half_tick);
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
  import rtg_pkg::*;
#(
  parameter int unsigned CMD_W    = 16,
  parameter logic [7:0]  OPCODE   = 8'hC8,
  parameter int unsigned BASE_DIV = 29,
  parameter int unsigned SLOW_DIV = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             bit_tick,
  output logic             half_tick
);
  rate_cfg_t pend_cfg;
  rate_cfg_t act_cfg;
  logic      stage_en;
  logic      wrap;

  rtg_cmd_decode #(
    .CMD_W    (CMD_W),
    .OP_W     (8),
    .OPCODE   (OPCODE),
    .RESET_CFG(RATE_DEFAULT)
  ) u_cmd (
    .clk     (clk),
    .rst     (rst),
    .cmd_wr  (cmd_wr),
    .cmd_word(cmd_word),
    .load    (wrap),
    .pend_cfg(pend_cfg),
    .act_cfg (act_cfg)
  );

  rtg_prescale #(
    .BASE_DIV(BASE_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (wrap),
    .slow    (act_cfg.slow),
    .stage_en(stage_en)
  );

  rtg_bit_div u_div (
    .clk     (clk),
    .rst     (rst),
    .stage_en(stage_en),
    .div     (act_cfg.div),
    .wrap    (wrap),
    .bit_tick(bit_tick)
  );

  rtg_half_mark #(
    .BASE_DIV(BASE_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_half (
    .clk      (clk),
    .rst      (rst),
    .restart  (wrap),
    .act_cfg  (act_cfg),
    .half_tick(half_tick)
  );

  // R4: mid-bit and end-of-bit pulses never overlap
  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
    !(bit_tick && half_tick));

  // R1: outputs are quiet in the cycle after reset is applied
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!bit_tick && !half_tick));
endmodule

// File: tb/tb_rate_tick_gen.sv
`timescale 1ns/1ps
module tb_rate_tick_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_word = 16'h0000;
  logic        bit_tick;
  logic        half_tick;

  int total = 0;
  int bad   = 0;
  longint cyc = 0;
  longint prev_tick_cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rate_tick_gen dut (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr),
    .cmd_word (cmd_word),
    .bit_tick (bit_tick),
    .half_tick(half_tick)
  );

  // behavioural reference
  int ph = 0;
  int pend_r = 35, pend_cs = 0, act_r = 35, act_cs = 0;
  bit exp_bit = 0, exp_half = 0;

  function automatic int period_of(int r, int cs);
    return 29 * (r + 1) * (cs != 0 ? 8 : 1);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      ph = 0; pend_r = 35; pend_cs = 0; act_r = 35; act_cs = 0;
      exp_bit = 0; exp_half = 0;
    end else begin
      int per;
      int nr, ncs;
      bit acc;
      per      = period_of(act_r, act_cs);
      exp_bit  = (ph == per - 1);
      exp_half = (ph == per / 2 - 1);
      acc = cmd_wr && (cmd_word[15:8] == 8'hC8);
      nr  = int'(cmd_word[6:0]);
      ncs = int'(cmd_word[7]);
      if (ph == per - 1) begin
        ph = 0; act_r = pend_r; act_cs = pend_cs;
      end else begin
        ph = ph + 1;
      end
      if (acc) begin pend_r = nr; pend_cs = ncs; end
    end
  end

  // cycle-by-cycle comparison
  bit last_bit = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      total++;
      if (bit_tick !== exp_bit) begin
        bad++;
        $display("FAIL R2 bit_tick at cycle %0d actual=%0b expected=%0b", cyc, bit_tick, exp_bit);
      end
      total++;
      if (half_tick !== exp_half) begin
        bad++;
        $display("FAIL R4 half_tick at cycle %0d actual=%0b expected=%0b", cyc, half_tick, exp_half);
      end
      if (last_bit) begin
        total++;
        if (bit_tick !== 1'b0) begin
          bad++;
          $display("FAIL R3 tick width actual=%0b expected=0", bit_tick);
        end
      end
      last_bit = bit_tick;
    end
  end

  task automatic check_eq(input string tag, input longint act, input longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic expect_period(input string tag, input longint expv);
    longint iv;
    do @(negedge clk); while (bit_tick !== 1'b1);
    iv = cyc - prev_tick_cyc;
    prev_tick_cyc = cyc;
    check_eq(tag, iv, expv);
  endtask

  task automatic write_cmd(input logic [15:0] w);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = w;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_word = 16'h0000;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check_eq("R1 bit_tick in reset", longint'(bit_tick), 0);
    check_eq("R1 half_tick in reset", longint'(half_tick), 0);
    rst = 1'b0;
    prev_tick_cyc = cyc;
    expect_period("R1 first tick after reset", 1044);
    expect_period("R2 default period", 1044);
    // R6: foreign operation codes
    write_cmd(16'hC900);
    write_cmd(16'h4880);
    expect_period("R6 foreign write ignored", 1044);
    expect_period("R6 still default", 1044);
    // R7: change applies at boundary; R9 fastest setting
    write_cmd(16'hC800);
    expect_period("R7 period in progress kept", 1044);
    expect_period("R9 R=0 cs=0", 29);
    // R8: two writes in one period, last one wins; R5 cs in bit 7
    write_cmd(16'hC80A);
    write_cmd(16'hC885);
    expect_period("R7 old period before switch", 29);
    expect_period("R8 last write wins", 1392);
    expect_period("R5 cs=1 R=5", 1392);
    // R9 slowest setting
    write_cmd(16'hC8FF);
    expect_period("R7 slow switch waits", 1392);
    expect_period("R9 R=127 cs=1", 29696);
    write_cmd(16'hC823);
    expect_period("R7 return waits", 29696);
    expect_period("R2 back to default", 1044);
    repeat (3) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule